// File: doc/BRIEF.md
# Video Controller Control-Port Decoder

This block sits behind the 16-bit control port of a video display controller and turns the words written there into decoded actions. A word whose two top bits are `10` writes one configuration register at once. Every other word is the first half of a two-word command; the next control word supplies the second half. A finished command selects an access target type and a 17-bit access address. It may also start a DMA job, using the method, length and source held in the configuration registers.

Every data-port access steps the access address by a programmable amount. A data write is also the trigger for a pending fill job. The memory arrays and the engines that move DMA data are outside the block. They receive the decoded register writes and DMA start pulses from its outputs. They report the end of a job on `dma_done`, which makes the block clear the length and advance the source.

Top module: `vdc_ctrl_decoder`

## Requirements
- R1: After reset, `cmd_pending` is 0, `acc_type` is 0, `acc_addr` is 0, and `reg_we` and `dma_start` are 0. All configuration registers are 0, so `dma_len` reads 65536.
- R2: When no command is pending, a control word with bits 15:14 = `10` produces a one-cycle `reg_we` in the next cycle, with `reg_idx` = bits 12:8 and `reg_val` = bits 7:0. It also sets `acc_type` to 0.
- R3: While bit 2 of register 1 is 0, a register write with an index above 10 produces no `reg_we` and changes no register, but it still clears `acc_type`. Index 10 is always accepted.
- R4: When no command is pending, any control word whose bits 15:14 are not `10` sets `cmd_pending` and leaves `acc_type` and `acc_addr` unchanged.
- R5: A control word arriving while a command is pending completes it and clears `cmd_pending`, whatever its top bits are. With first word F and second word S, `acc_type` = {S[5:4], F[15:14]} and `acc_addr` = {S[2], S[1:0], F[13:0]}.
- R6: Bit 7 of the second word requests DMA only while bit 4 of register 1 is 1. Otherwise the previously stored request bit replaces it. The stored bit is cleared by `dma_done`.
- R7: `dma_method` is register 23 bits 7:6. For methods 0, 1 and 3, a DMA request gives a one-cycle `dma_start` in the cycle after the second word. Method 2 (fill) gives no pulse then; the next data write gives one, and data reads do not.
- R8: `dma_len` is {register 20, register 19}, and a value of 0 means 65536.
- R9: Each data access with no command pending adds register 15 to `acc_addr[15:0]`. A carry out of bit 15 toggles `acc_addr[16]`.
- R10: A data access while a command is pending completes the command using the previous second word, clears `cmd_pending`, and then applies the R9 step to the new address.
- R11: On `dma_done`, registers 19 and 20 become 0 and the 16-bit source {register 22, register 21} advances by the length in effect. `dma_src` is {register 23 bits 5:0, register 22, register 21}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control-port write strobe; a data access in the same cycle is ignored |
| ctl_data | input | 16 | Control word |
| dat_acc | input | 1 | Data-port access strobe |
| dat_wr | input | 1 | Qualifies `dat_acc`: 1 = write, 0 = read |
| dma_done | input | 1 | Current DMA job finished |
| cmd_pending | output | 1 | First command word held |
| acc_type | output | 4 | Decoded access target type |
| acc_addr | output | 17 | Access address |
| reg_we | output | 1 | Register write pulse |
| reg_idx | output | 5 | Index of the written register |
| reg_val | output | 8 | Value written |
| dma_start | output | 1 | DMA start pulse |
| dma_method | output | 2 | DMA method |
| dma_len | output | 17 | DMA length in words |
| dma_src | output | 22 | DMA source |

## Verification
Faults in the pending flag show up on the very next control word. A lost flag turns a second word into a new first word or a register write, and `acc_type`/`acc_addr` are wrong one cycle later. A wrong stored request bit or a wrong fill-armed state shows up as a missing or extra `dma_start` on the following command or data write. A bad increment or carry handling shows in `acc_addr` one cycle after the access, and it stays wrong for every later access until the next command reloads the address.

// File: rtl/vdc_ctrl_pkg.sv
package vdc_ctrl_pkg;
    parameter int unsigned WORD_W     = 16;
    parameter int unsigned VAL_W      = 8;
    parameter int unsigned IDX_W      = 5;
    parameter int unsigned TYPE_W     = 4;
    parameter int unsigned COMPAT_TOP = 10;

    localparam int unsigned CMD_W  = 2 * WORD_W;
    localparam int unsigned ADDR_W = WORD_W + 1;
    localparam int unsigned LEN_W  = WORD_W + 1;
    localparam int unsigned SRC_W  = 2 * VAL_W + 6;

    localparam logic [IDX_W-1:0] RI_MODE    = IDX_W'(1);
    localparam logic [IDX_W-1:0] RI_STEP    = IDX_W'(15);
    localparam logic [IDX_W-1:0] RI_LEN_LO  = IDX_W'(19);
    localparam logic [IDX_W-1:0] RI_LEN_HI  = IDX_W'(20);
    localparam logic [IDX_W-1:0] RI_SRC_LO  = IDX_W'(21);
    localparam logic [IDX_W-1:0] RI_SRC_MID = IDX_W'(22);
    localparam logic [IDX_W-1:0] RI_SRC_HI  = IDX_W'(23);

    localparam int unsigned MODE_EXT_BIT  = 2;
    localparam int unsigned MODE_DMAE_BIT = 4;
    localparam int unsigned CMD_REQ_BIT   = 7;

    typedef enum logic [1:0] {
        DM_XFER_A = 2'd0,
        DM_XFER_B = 2'd1,
        DM_FILL   = 2'd2,
        DM_COPY   = 2'd3
    } dma_mode_e;

    typedef struct packed {
        logic                pending;
        logic [CMD_W-1:0]    cmd;
        logic [TYPE_W-1:0]   acc_type;
        logic [ADDR_W-1:0]   acc_addr;
        logic [VAL_W-1:0]    mode;
        logic [VAL_W-1:0]    step;
        logic [VAL_W-1:0]    len_lo;
        logic [VAL_W-1:0]    len_hi;
        logic [VAL_W-1:0]    src_lo;
        logic [VAL_W-1:0]    src_mid;
        logic [VAL_W-1:0]    src_hi;
        logic                reg_we;
        logic [IDX_W-1:0]    reg_idx;
        logic [VAL_W-1:0]    reg_val;
        logic                dma_start;
        logic                fill_armed;
    } dec_state_t;
endpackage

// File: rtl/vdc_cmd_unpack.sv
module vdc_cmd_unpack
    import vdc_ctrl_pkg::*;
(
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [TYPE_W-1:0] tgt_type,
    output logic [ADDR_W-1:0] tgt_addr
);
    // Target type: low-word bits 5:4 above high-word bits 15:14.
    assign tgt_type = {cmd_word[5:4], cmd_word[31:30]};
    // Address: bit 16 from low bit 2, bits 15:14 from low 1:0, rest from high word.
    assign tgt_addr = {cmd_word[2], cmd_word[1:0], cmd_word[29:16]};

    logic unused_bits;
    assign unused_bits = ^{cmd_word[15:6], cmd_word[3]};
endmodule

// File: rtl/vdc_addr_step.sv
module vdc_addr_step
    import vdc_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [VAL_W-1:0]  step,
    output logic [ADDR_W-1:0] addr_out
);
    logic [WORD_W:0] sum;
    assign sum      = {1'b0, addr_in[WORD_W-1:0]} + {{(WORD_W + 1 - VAL_W){1'b0}}, step};
    assign addr_out = {addr_in[ADDR_W-1] ^ sum[WORD_W], sum[WORD_W-1:0]};
endmodule

// File: rtl/vdc_ctrl_decoder.sv
module vdc_ctrl_decoder
    import vdc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [WORD_W-1:0] ctl_data,
    input  logic              dat_acc,
    input  logic              dat_wr,
    input  logic              dma_done,
    output logic              cmd_pending,
    output logic [TYPE_W-1:0] acc_type,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [VAL_W-1:0]  reg_val,
    output logic              dma_start,
    output logic [1:0]        dma_method,
    output logic [LEN_W-1:0]  dma_len,
    output logic [SRC_W-1:0]  dma_src
);
    dec_state_t st_q, st_d;

    logic              ext_mode;
    logic              dma_en;
    logic [VAL_W-1:0]  inc_step;
    logic [WORD_W-1:0] low_word;
    logic [CMD_W-1:0]  cmd_eff;
    logic [TYPE_W-1:0] unp_type;
    logic [ADDR_W-1:0] unp_addr;
    logic [ADDR_W-1:0] step_base;
    logic [ADDR_W-1:0] stepped_addr;
    logic [WORD_W-1:0] len_word;
    logic [LEN_W-1:0]  len_full;

    assign ext_mode = st_q.mode[MODE_EXT_BIT];
    assign dma_en   = st_q.mode[MODE_DMAE_BIT];
    assign inc_step = st_q.step;
    assign len_word = {st_q.len_hi, st_q.len_lo};
    assign len_full = (len_word == '0) ? LEN_W'(1) << WORD_W : {1'b0, len_word};

    // Second word with the request bit honoured or replaced by the stored one.
    always_comb begin
        low_word = ctl_data;
        if (!dma_en) begin
            low_word[CMD_REQ_BIT] = st_q.cmd[CMD_REQ_BIT];
        end
        cmd_eff = {st_q.cmd[CMD_W-1:WORD_W], ctl_wr ? low_word : st_q.cmd[WORD_W-1:0]};
    end

    vdc_cmd_unpack u_unpack (
        .cmd_word (cmd_eff),
        .tgt_type (unp_type),
        .tgt_addr (unp_addr)
    );

    assign step_base = st_q.pending ? unp_addr : st_q.acc_addr;

    vdc_addr_step u_step (
        .addr_in  (step_base),
        .step     (inc_step),
        .addr_out (stepped_addr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.reg_we    = 1'b0;
        st_d.dma_start = 1'b0;

        if (ctl_wr) begin
            if (st_q.pending) begin
                st_d.pending             = 1'b0;
                st_d.cmd[WORD_W-1:0]     = low_word;
                st_d.acc_type            = unp_type;
                st_d.acc_addr            = unp_addr;
                if (low_word[CMD_REQ_BIT]) begin
                    if (dma_mode_e'(st_q.src_hi[7:6]) == DM_FILL) begin
                        st_d.fill_armed = 1'b1;
                    end else begin
                        st_d.dma_start  = 1'b1;
                        st_d.fill_armed = 1'b0;
                    end
                end
            end else if (ctl_data[15:14] == 2'b10) begin
                st_d.acc_type = '0;
                if (ext_mode || (ctl_data[12:8] <= IDX_W'(COMPAT_TOP))) begin
                    st_d.reg_we  = 1'b1;
                    st_d.reg_idx = ctl_data[12:8];
                    st_d.reg_val = ctl_data[7:0];
                    case (ctl_data[12:8])
                        RI_MODE:    st_d.mode    = ctl_data[7:0];
                        RI_STEP:    st_d.step    = ctl_data[7:0];
                        RI_LEN_LO:  st_d.len_lo  = ctl_data[7:0];
                        RI_LEN_HI:  st_d.len_hi  = ctl_data[7:0];
                        RI_SRC_LO:  st_d.src_lo  = ctl_data[7:0];
                        RI_SRC_MID: st_d.src_mid = ctl_data[7:0];
                        RI_SRC_HI:  st_d.src_hi  = ctl_data[7:0];
                        default: ;
                    endcase
                end
            end else begin
                st_d.pending                  = 1'b1;
                st_d.cmd[CMD_W-1:WORD_W]      = ctl_data;
            end
        end else if (dat_acc) begin
            if (st_q.pending) begin
                st_d.pending  = 1'b0;
                st_d.acc_type = unp_type;
            end
            st_d.acc_addr = stepped_addr;
            if (dat_wr && st_q.fill_armed) begin
                st_d.dma_start  = 1'b1;
                st_d.fill_armed = 1'b0;
            end
        end

        if (dma_done) begin
            st_d.len_lo                = '0;
            st_d.len_hi                = '0;
            {st_d.src_mid, st_d.src_lo} = {st_q.src_mid, st_q.src_lo} + len_full[WORD_W-1:0];
            st_d.cmd[CMD_REQ_BIT]      = 1'b0;
            st_d.fill_armed            = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_pending = st_q.pending;
    assign acc_type    = st_q.acc_type;
    assign acc_addr    = st_q.acc_addr;
    assign reg_we      = st_q.reg_we;
    assign reg_idx     = st_q.reg_idx;
    assign reg_val     = st_q.reg_val;
    assign dma_start   = st_q.dma_start;
    assign dma_method  = st_q.src_hi[7:6];
    assign dma_len     = len_full;
    assign dma_src     = {st_q.src_hi[5:0], st_q.src_mid, st_q.src_lo};
endmodule

// File: rtl/vdc_ctrl_decoder_chk.sv
module vdc_ctrl_decoder_chk
    import vdc_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [WORD_W-1:0] ctl_data,
    input logic              dat_acc,
    input logic              cmd_pending,
    input logic [TYPE_W-1:0] acc_type,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              reg_we,
    input logic              dma_start,
    input logic              ext_mode,
    input logic [VAL_W-1:0]  inc_step
);
    logic [WORD_W:0] exp_sum;
    assign exp_sum = {1'b0, acc_addr[WORD_W-1:0]} + {{(WORD_W + 1 - VAL_W){1'b0}}, inc_step};

    p_regwr_clears_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !cmd_pending && ctl_data[15:14] == 2'b10) |=> (acc_type == '0));

    p_compat_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !cmd_pending && ctl_data[15:14] == 2'b10 && !ext_mode
         && ctl_data[12:8] > IDX_W'(COMPAT_TOP)) |=> !reg_we);

    p_first_word_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !cmd_pending && ctl_data[15:14] != 2'b10)
        |=> (cmd_pending && $stable(acc_addr) && $stable(acc_type)));

    p_second_word_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cmd_pending) |=> !cmd_pending);

    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_acc && !ctl_wr && !cmd_pending)
        |=> (acc_addr == {$past(acc_addr[ADDR_W-1]) ^ $past(exp_sum[WORD_W]),
                          $past(exp_sum[WORD_W-1:0])}));

    p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);
endmodule

bind vdc_ctrl_decoder vdc_ctrl_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_data    (ctl_data),
    .dat_acc     (dat_acc),
    .cmd_pending (cmd_pending),
    .acc_type    (acc_type),
    .acc_addr    (acc_addr),
    .reg_we      (reg_we),
    .dma_start   (dma_start),
    .ext_mode    (ext_mode),
    .inc_step    (inc_step)
);

// File: tb/vdc_ctrl_decoder_bench.sv
module vdc_ctrl_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_data = '0;
    logic        dat_acc = 1'b0;
    logic        dat_wr = 1'b0;
    logic        dma_done = 1'b0;
    logic        cmd_pending;
    logic [3:0]  acc_type;
    logic [16:0] acc_addr;
    logic        reg_we;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_val;
    logic        dma_start;
    logic [1:0]  dma_method;
    logic [16:0] dma_len;
    logic [21:0] dma_src;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vdc_ctrl_decoder u_vdc_ctrl_decoder (
        .clk, .rst_n, .ctl_wr, .ctl_data, .dat_acc, .dat_wr, .dma_done,
        .cmd_pending, .acc_type, .acc_addr, .reg_we, .reg_idx, .reg_val,
        .dma_start, .dma_method, .dma_len, .dma_src
    );

    // {kind(0 ctl,1 read,2 write), data, type, addr, pending, reg_we}
    localparam logic [40:0] VEC [16] = '{
        {2'd0, 16'h8104, 4'h0, 17'h00000, 1'b0, 1'b1}, // R2 reg1 = 04
        {2'd0, 16'h8F02, 4'h0, 17'h00000, 1'b0, 1'b1}, // R2 step = 2
        {2'd0, 16'h4000, 4'h0, 17'h00000, 1'b1, 1'b0}, // R4 first word
        {2'd0, 16'h0000, 4'h1, 17'h00000, 1'b0, 1'b0}, // R5
        {2'd2, 16'h0000, 4'h1, 17'h00002, 1'b0, 1'b0}, // R9
        {2'd0, 16'h6ABC, 4'h1, 17'h00002, 1'b1, 1'b0}, // R4
        {2'd0, 16'h0016, 4'h5, 17'h1AABC, 1'b0, 1'b0}, // R5 scattered fields
        {2'd1, 16'h0000, 4'h5, 17'h1AABE, 1'b0, 1'b0}, // R9
        {2'd0, 16'h8F80, 4'h0, 17'h1AABE, 1'b0, 1'b1}, // R2 clears type
        {2'd0, 16'h7FF0, 4'h0, 17'h1AABE, 1'b1, 1'b0}, // R4
        {2'd0, 16'h0003, 4'h1, 17'h0FFF0, 1'b0, 1'b0}, // R5
        {2'd2, 16'h0000, 4'h1, 17'h10070, 1'b0, 1'b0}, // R9 carry toggles bit 16
        {2'd1, 16'h0000, 4'h1, 17'h100F0, 1'b0, 1'b0}, // R9
        {2'd0, 16'hC000, 4'h1, 17'h100F0, 1'b1, 1'b0}, // R4 top bits 11
        {2'd2, 16'h0000, 4'h3, 17'h0C080, 1'b0, 1'b0}, // R10 reuse low word
        {2'd0, 16'h9005, 4'h0, 17'h0C080, 1'b0, 1'b1}  // R3 ext mode accepts reg 16
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic op(input int kind, input logic [15:0] d);
        @(negedge clk);
        ctl_wr   = (kind == 0);
        dat_acc  = (kind != 0);
        dat_wr   = (kind == 2);
        ctl_data = d;
        @(negedge clk);
        ctl_wr  = 1'b0;
        dat_acc = 1'b0;
        dat_wr  = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic cmd(input logic [15:0] w1, input logic [15:0] w2);
        op(0, w1);
        op(0, w2);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pending", 32'(cmd_pending), 0);
        chk("R1 type", 32'(acc_type), 0);
        chk("R1 addr", 32'(acc_addr), 0);
        chk("R1 len", 32'(dma_len), 32'h10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulses", 32'({reg_we, dma_start}), 0);

        // R3: compat mode drops reg 15 before ext mode is enabled
        op(0, 16'h8F44);
        chk("R3 drop reg15", 32'(reg_we), 0);
        op(1, 16'h0000);
        chk("R3 step unchanged", 32'(acc_addr), 0);

        for (int i = 0; i < 16; i++) begin
            op(int'(VEC[i][40:39]), VEC[i][38:23]);
            chk($sformatf("R2/R4/R5/R9/R10 vec%0d type", i), 32'(acc_type), 32'(VEC[i][22:19]));
            chk($sformatf("R5/R9/R10 vec%0d addr", i), 32'(acc_addr), 32'(VEC[i][18:2]));
            chk($sformatf("R4/R5 vec%0d pending", i), 32'(cmd_pending), 32'(VEC[i][1]));
            chk($sformatf("R2/R3 vec%0d reg_we", i), 32'(reg_we), 32'(VEC[i][0]));
        end

        // R3: back to compat mode, ignored write still clears type
        op(0, 16'h8100);
        cmd(16'h4000, 16'h0000);
        chk("R3 type set", 32'(acc_type), 1);
        op(0, 16'h8B55);
        chk("R3 idx11 dropped", 32'(reg_we), 0);
        chk("R3 type cleared", 32'(acc_type), 0);
        op(0, 16'h8A33);
        chk("R3 idx10 accepted", 32'(reg_we), 1);
        chk("R2 idx", 32'(reg_idx), 10);
        chk("R2 val", 32'(reg_val), 32'h33);

        // R8 / R7 / R11: memory transfer
        op(0, 16'h8114);
        chk("R8 zero length", 32'(dma_len), 32'h10000);
        op(0, 16'h9310);
        op(0, 16'h9500);
        op(0, 16'h9612);
        op(0, 16'h9700);
        chk("R8 length", 32'(dma_len), 16);
        chk("R11 src", 32'(dma_src), 32'h1200);
        cmd(16'h4000, 16'h0080);
        chk("R7 start xfer", 32'(dma_start), 1);
        chk("R7 method", 32'(dma_method), 0);
        done_pulse();
        chk("R11 len cleared", 32'(dma_len), 32'h10000);
        chk("R11 src advanced", 32'(dma_src), 32'h1210);

        // R6: request ignored when disabled, sticky bit reused
        op(0, 16'h8104);
        cmd(16'h4000, 16'h0080);
        chk("R6 disabled no start", 32'(dma_start), 0);
        op(0, 16'h8114);
        cmd(16'h4000, 16'h0080);
        chk("R6 enabled start", 32'(dma_start), 1);
        op(0, 16'h8104);
        cmd(16'h4000, 16'h0000);
        chk("R6 sticky start", 32'(dma_start), 1);
        done_pulse();
        cmd(16'h4000, 16'h0080);
        chk("R6 cleared by done", 32'(dma_start), 0);

        // R7 fill: armed by command, started by next data write only
        op(0, 16'h8114);
        op(0, 16'h9304);
        op(0, 16'h9780);
        cmd(16'h4000, 16'h0080);
        chk("R7 fill no start on cmd", 32'(dma_start), 0);
        chk("R7 fill method", 32'(dma_method), 2);
        op(1, 16'h0000);
        chk("R7 fill read no start", 32'(dma_start), 0);
        op(2, 16'h0000);
        chk("R7 fill write start", 32'(dma_start), 1);
        done_pulse();
        op(2, 16'h0000);
        chk("R7 fill not repeated", 32'(dma_start), 0);

        // R7 copy, R8 two-byte length
        op(0, 16'h97C0);
        op(0, 16'h9302);
        op(0, 16'h9401);
        chk("R8 len 0102", 32'(dma_len), 32'h0102);
        cmd(16'h4000, 16'h0080);
        chk("R7 copy start", 32'(dma_start), 1);
        chk("R7 copy method", 32'(dma_method), 3);
        @(negedge clk);
        chk("R7 single pulse", 32'(dma_start), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule